// File: doc/BRIEF.md
# Four-Plane Pixel Write Engine

This block connects a byte-wide CPU bus to four bit planes that share a single byte address. Each plane byte holds one bit for each of eight horizontally adjacent pixels. Bit 7 is the leftmost pixel. A pixel's 4-bit colour is made from the same bit position in planes 0 to 3. A small indexed register file is reached through two ports: the index port selects a register and the data port reads or writes it. A 16-bit write to the index port sets both the index and the register value in one transaction.

A CPU memory read captures the addressed byte of all four planes into four 8-bit latches. The CPU receives only the byte of the plane chosen by the read-select register. A CPU memory write updates all four planes at once. For each plane, the CPU byte is rotated right. Where the fill-enable bit for that plane is set, the rotated byte is replaced by that plane's fill bit copied to all eight positions. The result is then combined with the plane's latch by copy, AND, OR or XOR. Finally the pixel mask decides, bit by bit, whether the new value or the latch value is stored.

Top module: `gfx_plane_ctrl`

## Requirements
- R1: After synchronous reset, the index, all nine registers, the four latches and `io_rdata` are zero, and `mem_ack` is low.
- R2: A byte write with `io_sel`=0 sets the index. A byte write with `io_sel`=1 stores into register[index]. A read with `io_sel`=1 returns register[index] on `io_rdata` in the cycle after `io_rd`, and a read with `io_sel`=0 returns the index. Bits a register does not implement read as zero. The implemented bits are: indices 0, 1, 2 and 7 use bits [3:0]; index 3 uses [4:0]; index 4 uses [1:0]; indices 5, 6 and 8 use [7:0].
- R3: A write with `io_sel`=0 and `io_word`=1 sets the index from `io_wdata[7:0]` and, in the same transaction, writes `io_wdata[15:8]` into the register that this new index selects.
- R4: A register write to an index above 8 changes no register, and a data-port read at such an index returns zero. The index itself still holds and reads back the full 8-bit value.
- R5: When `mem_rd` is asserted without `mem_wr`, `mem_ack` is high in exactly the following cycle. While it is high, `mem_rdata` equals the byte of plane register4[1:0] at the read address.
- R6: Every memory read loads the addressed byte of all four planes into the latches. Latches hold their value at all other times.
- R7: Register 3 bits [2:0] give a right-rotate count from 0 to 7, applied to the CPU write byte.
- R8: Register 3 bits [4:3] select how the per-plane source is combined with that plane's latch: 00 copy, 01 AND, 10 OR, 11 XOR.
- R9: If register 1 bit p is 1, the source for plane p is register 0 bit p repeated in all 8 bits, in place of the rotated CPU byte.
- R10: Register 8 is the pixel mask. A 1 bit stores the function result; a 0 bit stores the latch bit.
- R11: Every `mem_wr` writes all four planes at `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Register-port write strobe |
| io_rd | input | 1 | Register-port read strobe |
| io_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| io_word | input | 1 | 16-bit write to the index port |
| io_wdata | input | 16 | Register-port write data |
| io_rdata | output | 8 | Register-port read data, registered |
| mem_wr | input | 1 | Plane memory write strobe |
| mem_rd | input | 1 | Plane memory read strobe |
| mem_addr | input | ADDR_W | Shared byte address |
| mem_wdata | input | 8 | CPU write byte |
| mem_rdata | output | 8 | Selected plane byte, valid while mem_ack is high |
| mem_ack | output | 1 | Read acknowledge, high one cycle after mem_rd |

## Verification
Before any read, a masked-off write is issued. This exposes latches that were not cleared on reset, because stale latch bits would reach the planes. Copying one address to another with an all-zero mask shows whether every latch is captured on a read; a design that loads only the selected plane would corrupt the other three. The rotate check uses 0x81 rotated by three and expects 0x30. A design that rotates left, or that uses the 16-bit form and writes the old index instead of the new one, stores different values. Random register settings mixed with reads and writes, checked plane by plane against a bench model, catch swapped function encodings, set/reset applied to the wrong plane and inverted mask polarity.

// File: rtl/gfxc_pkg.sv
package gfxc_pkg;
  localparam int PLANES = 4;
  localparam int PSEL_W = $clog2(PLANES);
  localparam int REGS   = 9;
  localparam logic [7:0] REG_LAST = 8'(REGS - 1);

  localparam logic [3:0] IX_FILL    = 4'd0;
  localparam logic [3:0] IX_FILL_EN = 4'd1;
  localparam logic [3:0] IX_ROTFN   = 4'd3;
  localparam logic [3:0] IX_RDSEL   = 4'd4;
  localparam logic [3:0] IX_PIXMASK = 4'd8;

  typedef enum logic [1:0] {FN_PASS = 2'b00, FN_AND = 2'b01, FN_OR = 2'b10, FN_XOR = 2'b11} alu_fn_e;

  function automatic logic [7:0] field_mask(input logic [7:0] idx);
    case (idx)
      8'd0, 8'd1, 8'd2, 8'd7: field_mask = 8'h0F;
      8'd3:                   field_mask = 8'h1F;
      8'd4:                   field_mask = 8'h03;
      8'd5, 8'd6, 8'd8:       field_mask = 8'hFF;
      default:                field_mask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/gfxc_regs.sv
module gfxc_regs
  import gfxc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic                io_sel,
  input  logic                io_word,
  input  logic [15:0]         io_wdata,
  output logic [7:0]          io_rdata,
  output logic [PLANES-1:0]   fill,
  output logic [PLANES-1:0]   fill_en,
  output logic [2:0]          rot,
  output alu_fn_e             fn,
  output logic [PSEL_W-1:0]   rd_plane,
  output logic [7:0]          pix_mask
);
  logic [7:0] idx_q;
  logic [7:0] regs_q [REGS];
  logic [REGS*8-1:0] regs_flat;
  logic [7:0] wr_idx, wr_val, rd_val;
  logic       wr_go;

  // the 16-bit form addresses the register named by its own low byte
  assign wr_idx = io_sel ? idx_q : io_wdata[7:0];
  assign wr_val = io_sel ? io_wdata[7:0] : io_wdata[15:8];
  assign wr_go  = io_wr && (io_sel || io_word) && (wr_idx <= REG_LAST);
  assign rd_val = (idx_q <= REG_LAST) ? regs_q[idx_q[3:0]] : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      io_rdata <= '0;
      for (int i = 0; i < REGS; i++) regs_q[i] <= '0;
    end else begin
      if (io_wr && !io_sel) idx_q <= io_wdata[7:0];
      if (wr_go) regs_q[wr_idx[3:0]] <= wr_val & field_mask(wr_idx);
      if (io_rd) io_rdata <= io_sel ? rd_val : idx_q;
    end
  end

  always_comb begin
    for (int i = 0; i < REGS; i++) regs_flat[i*8 +: 8] = regs_q[i];
  end

  assign fill     = regs_q[IX_FILL][PLANES-1:0];
  assign fill_en  = regs_q[IX_FILL_EN][PLANES-1:0];
  assign rot      = regs_q[IX_ROTFN][2:0];
  assign fn       = alu_fn_e'(regs_q[IX_ROTFN][4:3]);
  assign rd_plane = regs_q[IX_RDSEL][PSEL_W-1:0];
  assign pix_mask = regs_q[IX_PIXMASK];

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (idx_q == 8'h00 && io_rdata == 8'h00 && regs_flat == '0));

  a_r2_unused_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_sel) |=> ((io_rdata & ~field_mask($past(idx_q))) == 8'h00));

  a_r4_high_index_ignored: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_sel && idx_q > REG_LAST) |=> $stable(regs_flat));
endmodule

// File: rtl/gfxc_lane.sv
module gfxc_lane
  import gfxc_pkg::*;
(
  input  logic [7:0] cpu_byte,
  input  logic [2:0] rot,
  input  alu_fn_e    fn,
  input  logic       fill_bit,
  input  logic       fill_on,
  input  logic [7:0] pix_mask,
  input  logic [7:0] latch,
  output logic [7:0] result
);
  logic [7:0] rotated, src, alu;

  always_comb begin
    for (int i = 0; i < 8; i++) rotated[i] = cpu_byte[3'(i) + rot];
    src = fill_on ? {8{fill_bit}} : rotated;
    case (fn)
      FN_AND:  alu = src & latch;
      FN_OR:   alu = src | latch;
      FN_XOR:  alu = src ^ latch;
      default: alu = src;
    endcase
    result = (alu & pix_mask) | (latch & ~pix_mask);
  end
endmodule

// File: rtl/gfxc_plane_ram.sv
module gfxc_plane_ram #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // output register doubles as the plane latch
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[addr];
  end

  a_r6_latch_holds: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(q));
endmodule

// File: rtl/gfx_plane_ctrl.sv
module gfx_plane_ctrl
  import gfxc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              io_sel,
  input  logic              io_word,
  input  logic [15:0]       io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              mem_wr,
  input  logic              mem_rd,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_wdata,
  output logic [7:0]        mem_rdata,
  output logic              mem_ack
);
  logic [PLANES-1:0] fill, fill_en;
  logic [2:0]        rot;
  alu_fn_e           fn;
  logic [PSEL_W-1:0] rd_plane;
  logic [7:0]        pix_mask;
  logic [7:0]        lat   [PLANES];
  logic [7:0]        wbyte [PLANES];
  logic              rd_go, ack_q;

  assign rd_go = mem_rd && !mem_wr;

  gfxc_regs u_regs (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_sel(io_sel),
    .io_word(io_word), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .fill(fill), .fill_en(fill_en), .rot(rot), .fn(fn),
    .rd_plane(rd_plane), .pix_mask(pix_mask)
  );

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    gfxc_lane u_lane (
      .cpu_byte(mem_wdata), .rot(rot), .fn(fn), .fill_bit(fill[p]),
      .fill_on(fill_en[p]), .pix_mask(pix_mask), .latch(lat[p]),
      .result(wbyte[p])
    );
    gfxc_plane_ram #(.ADDR_W(ADDR_W)) u_ram (
      .clk(clk), .rst(rst), .we(mem_wr), .re(rd_go), .addr(mem_addr),
      .wdata(wbyte[p]), .q(lat[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= rd_go;
  end

  assign mem_ack   = ack_q;
  assign mem_rdata = lat[rd_plane];

  a_r5_ack_follows_read: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> mem_ack);

  a_r5_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
    !rd_go |=> !mem_ack);
endmodule

// File: tb/gfx_plane_ctrl_bench.sv
module gfx_plane_ctrl_bench;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic io_wr = 0, io_rd = 0, io_sel = 0, io_word = 0;
  logic [15:0] io_wdata = '0;
  logic [7:0]  io_rdata;
  logic mem_wr = 0, mem_rd = 0;
  logic [AW-1:0] mem_addr = '0;
  logic [7:0] mem_wdata = '0, mem_rdata;
  logic mem_ack;

  gfx_plane_ctrl #(.ADDR_W(AW)) u_gfx_plane_ctrl (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_sel(io_sel),
    .io_word(io_word), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] m_pl [4][DEPTH];
  logic [7:0] m_reg [9];
  logic [7:0] m_idx;
  logic [7:0] m_lat [4];

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] impl_bits(input logic [7:0] idx);
    case (idx)
      8'd0, 8'd1, 8'd2, 8'd7: return 8'h0F;
      8'd3: return 8'h1F;
      8'd4: return 8'h03;
      8'd5, 8'd6, 8'd8: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_lane(input int p, input logic [7:0] d);
    logic [7:0] r, s, a;
    int n;
    n = int'(m_reg[3][2:0]);
    r = (d >> n) | (d << (8 - n));
    s = m_reg[1][p] ? {8{m_reg[0][p]}} : r;
    case (m_reg[3][4:3])
      2'b01:   a = s & m_lat[p];
      2'b10:   a = s | m_lat[p];
      2'b11:   a = s ^ m_lat[p];
      default: a = s;
    endcase
    return (a & m_reg[8]) | (m_lat[p] & ~m_reg[8]);
  endfunction

  task automatic io_write(input logic sel, input logic word, input logic [15:0] d);
    @(negedge clk);
    io_wr = 1; io_sel = sel; io_word = word; io_wdata = d;
    @(negedge clk);
    io_wr = 0; io_word = 0;
    if (!sel) begin
      m_idx = d[7:0];
      if (word && d[7:0] <= 8'd8) m_reg[d[3:0]] = d[15:8] & impl_bits(d[7:0]);
    end else if (m_idx <= 8'd8) begin
      m_reg[m_idx[3:0]] = d[7:0] & impl_bits(m_idx);
    end
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] v);
    io_write(1'b0, 1'b1, {v, idx});
  endtask

  task automatic io_read(input logic sel, output logic [7:0] v);
    @(negedge clk);
    io_rd = 1; io_sel = sel;
    @(negedge clk);
    io_rd = 0;
    #1 v = io_rdata;
  endtask

  task automatic mem_read(input logic [AW-1:0] a, output logic [7:0] v, output logic ack);
    @(negedge clk);
    mem_rd = 1; mem_addr = a;
    @(negedge clk);
    mem_rd = 0;
    #1 ack = mem_ack; v = mem_rdata;
    for (int p = 0; p < 4; p++) m_lat[p] = m_pl[p][a];
  endtask

  task automatic mem_write(input logic [AW-1:0] a, input logic [7:0] d);
    for (int p = 0; p < 4; p++) m_pl[p][a] = exp_lane(p, d);
    @(negedge clk);
    mem_wr = 1; mem_addr = a; mem_wdata = d;
    @(negedge clk);
    mem_wr = 0;
  endtask

  task automatic check_addr(input string tag, input logic [AW-1:0] a);
    logic [7:0] v;
    logic ack;
    for (int p = 0; p < 4; p++) begin
      set_reg(8'd4, 8'(p));
      mem_read(a, v, ack);
      check(tag, v, m_pl[p][a]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic ack;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 9; i++) m_reg[i] = '0;
    for (int p = 0; p < 4; p++) m_lat[p] = '0;
    m_idx = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state of index, registers, ack and latches
    #1 check("R1 ack", {7'b0, mem_ack}, 8'h00);
    check("R1 io_rdata", io_rdata, 8'h00);
    io_read(1'b0, v); check("R1 index", v, 8'h00);
    for (int i = 0; i < 9; i++) begin
      io_write(1'b0, 1'b0, 16'(i));
      io_read(1'b1, v); check("R1 reg", v, 8'h00);
    end
    // mask is zero after reset, so this write stores the latches (zero)
    mem_write(8'd5, 8'hFF);
    check_addr("R1 latch", 8'd5);

    // clear the planes with set/reset fill 0
    set_reg(8'd1, 8'h0F); set_reg(8'd0, 8'h00); set_reg(8'd8, 8'hFF); set_reg(8'd3, 8'h00);
    for (int a = 0; a < DEPTH; a++) mem_write(AW'(a), 8'h00);

    // R2: byte writes, unused bits zero
    io_write(1'b0, 1'b0, 16'h0003);
    io_write(1'b1, 1'b0, 16'h00FF);
    io_read(1'b1, v); check("R2 masked", v, 8'h1F);
    io_read(1'b0, v); check("R2 index", v, 8'h03);
    io_write(1'b1, 1'b0, 16'h0000);

    // R3: 16-bit write
    io_write(1'b0, 1'b1, 16'h5A08);
    io_read(1'b0, v); check("R3 index", v, 8'h08);
    io_read(1'b1, v); check("R3 value", v, 8'h5A);

    // R4: indices above 8
    io_write(1'b0, 1'b0, 16'h0009);
    io_write(1'b1, 1'b0, 16'h0077);
    io_read(1'b1, v); check("R4 read zero", v, 8'h00);
    io_write(1'b0, 1'b1, 16'h770C);
    io_read(1'b0, v); check("R4 index", v, 8'h0C);
    io_write(1'b0, 1'b0, 16'h0008);
    io_read(1'b1, v); check("R4 reg8 kept", v, 8'h5A);

    // R9: set/reset on planes 0 and 2
    set_reg(8'd8, 8'hFF); set_reg(8'd1, 8'h05); set_reg(8'd0, 8'h01);
    mem_write(8'd10, 8'h3C);
    check_addr("R9", 8'd10);

    // R5: ack timing and selected plane
    set_reg(8'd4, 8'd1);
    mem_read(8'd10, v, ack);
    check("R5 ack", {7'b0, ack}, 8'h01);
    check("R5 data", v, 8'h3C);
    @(negedge clk); #1 check("R5 ack drop", {7'b0, mem_ack}, 8'h00);

    // R6: all-latch capture, copied with mask 0
    mem_read(8'd10, v, ack);
    set_reg(8'd8, 8'h00);
    mem_write(8'd20, 8'h00);
    check_addr("R6", 8'd20);
    check("R6 plane0", m_pl[0][20], 8'hFF);

    // R7: rotate right by 3
    set_reg(8'd1, 8'h00); set_reg(8'd8, 8'hFF); set_reg(8'd3, 8'h03);
    mem_write(8'd30, 8'h81);
    set_reg(8'd4, 8'd2);
    mem_read(8'd30, v, ack); check("R7 rotate", v, 8'h30);

    // R8: functions against latch
    for (int f = 1; f < 4; f++) begin
      mem_read(8'd10, v, ack);
      set_reg(8'd3, 8'(f << 3));
      mem_write(AW'(40 + f), 8'hA5);
      check_addr("R8", AW'(40 + f));
    end

    // R10: partial mask
    mem_read(8'd10, v, ack);
    set_reg(8'd3, 8'h00); set_reg(8'd8, 8'h0F);
    mem_write(8'd50, 8'h00);
    check_addr("R10", 8'd50);
    check("R10 plane0", m_pl[0][50], 8'hF0);

    // R11 with R5, R7-R10: random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [AW-1:0] a;
      op = int'($urandom % 4);
      a  = AW'($urandom % 16);
      case (op)
        0: begin
          case ($urandom % 5)
            0: set_reg(8'd0, 8'($urandom));
            1: set_reg(8'd1, 8'($urandom));
            2: set_reg(8'd3, 8'($urandom));
            3: set_reg(8'd4, 8'($urandom));
            default: set_reg(8'd8, 8'($urandom));
          endcase
        end
        1: begin
          mem_read(a, v, ack);
          check("R5 rand ack", {7'b0, ack}, 8'h01);
          check("R5 rand data", v, m_pl[m_reg[4][1:0]][a]);
        end
        2: mem_write(a, 8'($urandom));
        default: check_addr("R11 rand", a);
      endcase
    end

    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule